// File: doc/BRIEF.md
# Proximity Detector and Calibration Gate

This block sits behind the conversion sequencer of a capacitive touch front end. Once per completed conversion sequence it receives a strobe carrying one filtered result. Selected results are fed into a short fast FIFO, and the block then decides whether a finger is near the electrode. Two magnitude comparators form that decision. The first looks at how fast the signal is moving, using the spread between two FIFO words. The second looks at how far the fast average has drifted from the stored ambient (no-touch) level.

The decision gates the environmental calibration. Calibration is switched off the moment proximity is seen. It stays off for a hold-off period after proximity goes away, and that period is scaled differently in full-power and low-power operation. The block also handles a reading that sits above ambient by more than the recalibration level for too long. It treats this as a stuck baseline rather than a touch and emits a one-cycle forced-recalibration pulse. All of this timing is counted in sequences, meaning strobes, and not in clock cycles.

Top module: `prox_cal_gate`

## Requirements
- R1: After reset, the FIFO words are zero (`fast_avg_o` = 0). `cal_en_o` is 1 and `recal_o` is 0. With `ambient_i` = 0, `prox_o` is 0.
- R2: A skip counter decides which strobes are accepted into the FIFO. The first strobe after reset is accepted, and after that one strobe in every `skip_i`+1 is accepted. With `skip_i` = 0 every strobe is accepted.
- R3: The fast FIFO holds four 16-bit words and shifts on each accepted strobe. Word 0 is the newest and word 3 the oldest. `fast_avg_o` is floor(sum of the four words / 4), and it is valid from the cycle after the accepted strobe.
- R4: The rate comparator fires when |word 1 − word 3| > `det_rate_i`×16, with strict comparison. Word 1 is the second newest word.
- R5: The level comparator fires when |`fast_avg_o` − `ambient_i`| > `recal_lvl_i`×16, with strict comparison. `prox_o` is the OR of the two comparators.
- R6: Each strobe is one sequence tick, and the tick is evaluated one cycle after the strobe. On a tick where `prox_o` is 1, `cal_en_o` goes to 0 at the following clock edge, unless a forced recalibration happens on that same tick.
- R7: In full-power mode (`lp_mode_i` = 0), H = `hold_fp_i`×16. `cal_en_o` returns to 1 on the H-th consecutive tick without proximity, or on the first such tick when H = 0.
- R8: In low-power mode (`lp_mode_i` = 1), the same rule applies with H = `hold_lp_i`×4.
- R9: If proximity reappears during the hold-off, the hold-off count restarts from its full length.
- R10: The timeout limit T is `tmo_fp_i` in full-power mode and `tmo_lp_i` in low-power mode. When `fast_avg_o` − `ambient_i` > `recal_lvl_i`×16 holds on T consecutive ticks, `recal_o` pulses for one cycle after the T-th tick. That same edge sets `cal_en_o` to 1 and clears both the timeout count and the hold-off count. T = 0 disables forced recalibration.
- R11: `cal_en_o` and `recal_o` change only on the clock edge that follows a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid_i | input | 1 | One-cycle strobe per completed conversion sequence |
| smp_data_i | input | 16 | Filtered conversion result accompanying the strobe |
| ambient_i | input | 16 | Stored ambient (no-touch) value |
| lp_mode_i | input | 1 | 0 = full-power timing, 1 = low-power timing |
| det_rate_i | input | 6 | Rate comparator threshold, in units of 16 codes |
| recal_lvl_i | input | 8 | Level comparator and timeout threshold, in units of 16 codes |
| hold_fp_i | input | 4 | Full-power hold-off, in units of 16 sequences |
| hold_lp_i | input | 4 | Low-power hold-off, in units of 4 sequences |
| tmo_fp_i | input | 10 | Full-power forced-recalibration timeout, in sequences |
| tmo_lp_i | input | 6 | Low-power forced-recalibration timeout, in sequences |
| skip_i | input | 4 | Samples skipped between FIFO acceptances |
| prox_o | output | 1 | Proximity decision |
| cal_en_o | output | 1 | Calibration enable |
| recal_o | output | 1 | One-cycle forced-recalibration pulse |
| fast_avg_o | output | 16 | Mean of the four fast-FIFO words |

## Verification
The bench builds the block with its default parameters: 16-bit data, a four-word FIFO, two threshold shifts of 4, and hold-off shifts of 4 and 2. Keeping the configuration that small lets the bench sweep every one of the sixteen skip settings and every hold-off code in both power modes, and each sweep checks against an arithmetic closed form. Both comparators are driven to exactly their threshold and one code past it, in both signs. Timeouts are exercised in each mode, including the zero setting that disables them, together with a restart of the hold-off in mid-count.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  // Timing selection for the hold-off and timeout counters.
  typedef enum logic {
    PCG_FULL = 1'b0,
    PCG_LOW  = 1'b1
  } pcg_mode_e;
endpackage

// File: rtl/pcg_skip_fifo.sv
// Sample-skip counter plus a shift FIFO of DEPTH words and their mean (R2, R3).
module pcg_skip_fifo #(
  parameter int DW     = 16,
  parameter int DEPTH  = 4,
  parameter int SKIP_W = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      stb_i,
  input  logic [DW-1:0]             data_i,
  input  logic [SKIP_W-1:0]         skip_i,
  output logic                      acc_o,
  output logic [DEPTH-1:0][DW-1:0]  word_o,
  output logic [DW-1:0]             avg_o
);
  // DEPTH must be a power of two so the mean is a shift.
  localparam int AW    = $clog2(DEPTH);
  localparam int SUM_W = DW + AW;

  logic [SKIP_W-1:0]         scnt_q, scnt_d;
  logic [DEPTH-1:0][DW-1:0]  word_q;
  logic [SUM_W-1:0]          sum;

  // Skip counter: accept on a zero count, wrap after skip_i strobes.
  always_comb begin
    acc_o  = stb_i && (scnt_q == '0);
    scnt_d = scnt_q;
    if (stb_i) begin
      if (scnt_q >= skip_i) scnt_d = '0;
      else                  scnt_d = scnt_q + SKIP_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    scnt_q <= '0;
    else if (stb_i) scnt_q <= scnt_d;
  end

  // Word 0 takes the new sample, the others shift one place older.
  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    word_q[i] <= '0;
        else if (acc_o) word_q[i] <= data_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    word_q[i] <= '0;
        else if (acc_o) word_q[i] <= word_q[i-1];
      end
    end
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < DEPTH; i++) sum = sum + SUM_W'(word_q[i]);
    avg_o = DW'(sum >> AW);
  end

  assign word_o = word_q;
endmodule

// File: rtl/pcg_abs_cmp.sv
// |a - b| > lvl << SHIFT, evaluated in a width that cannot overflow (R4, R5).
module pcg_abs_cmp #(
  parameter int DW    = 16,
  parameter int FW    = 6,
  parameter int SHIFT = 4
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [FW-1:0] lvl_i,
  output logic          hit_o
);
  localparam int TW = FW + SHIFT;
  localparam int CW = ((DW > TW) ? DW : TW) + 1;

  logic [CW-1:0] ax, bx, mag, thr;

  always_comb begin
    ax    = CW'(a_i);
    bx    = CW'(b_i);
    mag   = (ax >= bx) ? (ax - bx) : (bx - ax);
    thr   = CW'(lvl_i) << SHIFT;
    hit_o = mag > thr;
  end
endmodule

// File: rtl/pcg_hold_timer.sv
// Calibration gate: hold-off after proximity and forced-recalibration timeout
// (R6 to R10), both advanced once per sequence tick (R11).
module pcg_hold_timer
  import pcg_pkg::*;
#(
  parameter int HOLD_W = 4,
  parameter int FP_SH  = 4,
  parameter int LP_SH  = 2,
  parameter int TFP_W  = 10,
  parameter int TLP_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              prox_i,
  input  logic              above_i,
  input  logic              lp_i,
  input  logic [HOLD_W-1:0] hold_fp_i,
  input  logic [HOLD_W-1:0] hold_lp_i,
  input  logic [TFP_W-1:0]  tmo_fp_i,
  input  logic [TLP_W-1:0]  tmo_lp_i,
  output logic              cal_en_o,
  output logic              recal_o
);
  localparam int SH_MAX = (FP_SH > LP_SH) ? FP_SH : LP_SH;
  localparam int HC_W   = HOLD_W + SH_MAX;
  localparam int TC_W   = (TFP_W > TLP_W) ? TFP_W : TLP_W;

  pcg_mode_e        mode;
  logic [HC_W-1:0]  hold_q, hold_d, hold_load;
  logic [TC_W-1:0]  tcnt_q, tcnt_d, tmo_lim;
  logic [TC_W:0]    tcnt_inc;
  logic             cal_q, cal_d;
  logic             recal_q, recal_d;

  assign mode = lp_i ? PCG_LOW : PCG_FULL;

  always_comb begin
    hold_load = (mode == PCG_LOW) ? (HC_W'(hold_lp_i) << LP_SH)
                                  : (HC_W'(hold_fp_i) << FP_SH);
    tmo_lim   = (mode == PCG_LOW) ? TC_W'(tmo_lp_i) : TC_W'(tmo_fp_i);
    tcnt_inc  = {1'b0, tcnt_q} + (TC_W+1)'(1);

    hold_d  = hold_q;
    tcnt_d  = tcnt_q;
    cal_d   = cal_q;
    recal_d = 1'b0;

    if (tick_i) begin
      // Timeout: consecutive ticks above ambient by the level.
      if (above_i && (tmo_lim != '0)) begin
        if (tcnt_inc >= {1'b0, tmo_lim}) begin
          recal_d = 1'b1;
          tcnt_d  = '0;
          hold_d  = '0;
          cal_d   = 1'b1;
        end else begin
          tcnt_d = tcnt_inc[TC_W-1:0];
        end
      end else begin
        tcnt_d = '0;
      end

      // Hold-off: reload while near, count down once clear.
      if (!recal_d) begin
        if (prox_i) begin
          cal_d  = 1'b0;
          hold_d = hold_load;
        end else if (hold_q > HC_W'(1)) begin
          cal_d  = 1'b0;
          hold_d = hold_q - HC_W'(1);
        end else begin
          cal_d  = 1'b1;
          hold_d = '0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      tcnt_q <= '0;
      cal_q  <= 1'b1;
    end else if (tick_i) begin
      hold_q <= hold_d;
      tcnt_q <= tcnt_d;
      cal_q  <= cal_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) recal_q <= 1'b0;
    else         recal_q <= recal_d;
  end

  assign cal_en_o = cal_q;
  assign recal_o  = recal_q;
endmodule

// File: rtl/prox_cal_gate.sv
module prox_cal_gate #(
  parameter int DW        = 16,
  parameter int DEPTH     = 4,
  parameter int SKIP_W    = 4,
  parameter int RATE_W    = 6,
  parameter int LVL_W     = 8,
  parameter int THR_SH    = 4,
  parameter int HOLD_W    = 4,
  parameter int HOLD_FPSH = 4,
  parameter int HOLD_LPSH = 2,
  parameter int TFP_W     = 10,
  parameter int TLP_W     = 6,
  parameter int RATE_NEW  = 1,
  parameter int RATE_OLD  = DEPTH - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [DW-1:0]     smp_data_i,
  input  logic [DW-1:0]     ambient_i,
  input  logic              lp_mode_i,
  input  logic [RATE_W-1:0] det_rate_i,
  input  logic [LVL_W-1:0]  recal_lvl_i,
  input  logic [HOLD_W-1:0] hold_fp_i,
  input  logic [HOLD_W-1:0] hold_lp_i,
  input  logic [TFP_W-1:0]  tmo_fp_i,
  input  logic [TLP_W-1:0]  tmo_lp_i,
  input  logic [SKIP_W-1:0] skip_i,
  output logic              prox_o,
  output logic              cal_en_o,
  output logic              recal_o,
  output logic [DW-1:0]     fast_avg_o
);
  logic [1:0]               rsync_q;
  logic                     rst_n;
  logic                     tick_q;
  logic                     fifo_acc;
  logic [DEPTH-1:0][DW-1:0] fifo_word;
  logic [DW-1:0]            fifo_avg;
  logic                     near_rate, near_lvl, above;

  // Reset: asserted asynchronously, released after two clock edges.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= '0;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  // Sequence tick: evaluated one cycle after the strobe, on updated FIFO data.
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= smp_valid_i;
  end

  pcg_skip_fifo #(
    .DW     (DW),
    .DEPTH  (DEPTH),
    .SKIP_W (SKIP_W)
  ) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .stb_i  (smp_valid_i),
    .data_i (smp_data_i),
    .skip_i (skip_i),
    .acc_o  (fifo_acc),
    .word_o (fifo_word),
    .avg_o  (fifo_avg)
  );

  pcg_abs_cmp #(
    .DW    (DW),
    .FW    (RATE_W),
    .SHIFT (THR_SH)
  ) u_cmp_rate (
    .a_i   (fifo_word[RATE_NEW]),
    .b_i   (fifo_word[RATE_OLD]),
    .lvl_i (det_rate_i),
    .hit_o (near_rate)
  );

  pcg_abs_cmp #(
    .DW    (DW),
    .FW    (LVL_W),
    .SHIFT (THR_SH)
  ) u_cmp_lvl (
    .a_i   (fifo_avg),
    .b_i   (ambient_i),
    .lvl_i (recal_lvl_i),
    .hit_o (near_lvl)
  );

  // Only an offset above ambient feeds the timeout (R10).
  assign above  = near_lvl && (fifo_avg > ambient_i);
  assign prox_o = near_rate || near_lvl;

  pcg_hold_timer #(
    .HOLD_W (HOLD_W),
    .FP_SH  (HOLD_FPSH),
    .LP_SH  (HOLD_LPSH),
    .TFP_W  (TFP_W),
    .TLP_W  (TLP_W)
  ) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .tick_i    (tick_q),
    .prox_i    (prox_o),
    .above_i   (above),
    .lp_i      (lp_mode_i),
    .hold_fp_i (hold_fp_i),
    .hold_lp_i (hold_lp_i),
    .tmo_fp_i  (tmo_fp_i),
    .tmo_lp_i  (tmo_lp_i),
    .cal_en_o  (cal_en_o),
    .recal_o   (recal_o)
  );

  assign fast_avg_o = fifo_avg;
endmodule

// File: rtl/pcg_chk.sv
module pcg_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic smp_valid_i,
  input logic acc_i,
  input logic tick_i,
  input logic prox_i,
  input logic cal_en_i,
  input logic recal_i
);
  assert_acc_on_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |-> smp_valid_i);

  assert_cal_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && prox_i) |=> (!cal_en_i || recal_i));

  assert_pulse_after_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recal_i |-> $past(tick_i));

  assert_pulse_enables_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recal_i |-> cal_en_i);

  assert_quiet_between_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(cal_en_i) && !recal_i));
endmodule

bind prox_cal_gate pcg_chk u_pcg_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_n),
  .smp_valid_i (smp_valid_i),
  .acc_i       (fifo_acc),
  .tick_i      (tick_q),
  .prox_i      (prox_o),
  .cal_en_i    (cal_en_o),
  .recal_i     (recal_o)
);

// File: tb/prox_cal_gate_tb_top.sv
module prox_cal_gate_tb_top;
  logic        clk;
  logic        rst_n;
  logic        stb;
  logic [15:0] data;
  logic [15:0] amb;
  logic        lp;
  logic [5:0]  det;
  logic [7:0]  lvl;
  logic [3:0]  hfp, hlp;
  logic [9:0]  tfp;
  logic [5:0]  tlp;
  logic [3:0]  skip;
  logic        prox, cal_en, recal;
  logic [15:0] avg;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Reference state kept by the bench.
  int m[4];
  int sc, hc, tc, mavg;
  bit mcal, mrec, mprox;

  prox_cal_gate dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .smp_valid_i (stb),
    .smp_data_i  (data),
    .ambient_i   (amb),
    .lp_mode_i   (lp),
    .det_rate_i  (det),
    .recal_lvl_i (lvl),
    .hold_fp_i   (hfp),
    .hold_lp_i   (hlp),
    .tmo_fp_i    (tfp),
    .tmo_lp_i    (tlp),
    .skip_i      (skip),
    .prox_o      (prox),
    .cal_en_o    (cal_en),
    .recal_o     (recal),
    .fast_avg_o  (avg)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic apply_reset();
    rst_n = 1'b0; stb = 1'b0; amb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 4; i++) m[i] = 0;
    sc = 0; hc = 0; tc = 0; mavg = 0; mcal = 1; mrec = 0;
    chk("R1 avg", int'(avg), 0);
    chk("R1 cal_en", int'(cal_en), 1);
    chk("R1 recal", int'(recal), 0);
    chk("R1 prox", int'(prox), 0);
  endtask

  task automatic step(input int d);
    int s, d1, d2, hh, tt;
    bit acc, above;
    @(negedge clk);
    chk("R10 pulse width", int'(recal), 0);
    stb = 1'b1; data = 16'(d);
    @(negedge clk);
    stb = 1'b0;
    acc = (sc == 0);
    sc  = (sc >= int'(skip)) ? 0 : sc + 1;
    if (acc) begin
      m[3] = m[2]; m[2] = m[1]; m[1] = m[0]; m[0] = d;
    end
    s     = m[0] + m[1] + m[2] + m[3];
    mavg  = s / 4;
    d1    = iabs(m[1] - m[3]);
    d2    = iabs(mavg - int'(amb));
    mprox = (d1 > int'(det) * 16) || (d2 > int'(lvl) * 16);
    above = (d2 > int'(lvl) * 16) && (mavg > int'(amb));
    hh    = lp ? int'(hlp) * 4 : int'(hfp) * 16;
    tt    = lp ? int'(tlp) : int'(tfp);
    mrec  = 0;
    if (above && tt != 0) begin
      tc++;
      if (tc >= tt) begin mrec = 1; tc = 0; hc = 0; mcal = 1; end
    end else tc = 0;
    if (!mrec) begin
      if (mprox)       begin mcal = 0; hc = hh; end
      else if (hc > 1) begin mcal = 0; hc--; end
      else             begin mcal = 1; hc = 0; end
    end
    @(negedge clk);
    chk("R3 avg", int'(avg), mavg);
    chk("R5 prox", int'(prox), int'(mprox));
    chk("R6 cal_en", int'(cal_en), int'(mcal));
    chk("R10 recal", int'(recal), int'(mrec));
  endtask

  task automatic settle();
    int g = 0;
    repeat (4) step(1000);
    while (!cal_en && g < 300) begin step(1000); g++; end
  endtask

  task automatic run_hold(input int h, input string tag, input bit restart);
    int n, g;
    settle();
    step(2000);
    chk("R6 cal off on proximity", int'(cal_en), 0);
    g = 0; while (prox && g < 20) begin step(1000); g++; end
    if (restart) begin
      repeat (5) step(1000);
      chk("R9 still held", int'(cal_en), 0);
      step(2000);
      chk("R9 cal off again", int'(cal_en), 0);
      g = 0; while (prox && g < 20) begin step(1000); g++; end
    end
    n = 1;
    while (!cal_en && n < 400) begin step(1000); n++; end
    chk(tag, n, (h == 0) ? 1 : h);
  endtask

  task automatic count_pulse(input int lim, input string tag);
    int n = 0;
    do begin step(1100); n++; end while (!recal && n < 100);
    chk(tag, n, lim);
    chk("R10 cal re-enabled", int'(cal_en), 1);
  endtask

  initial begin
    rst_n = 1'b0; stb = 1'b0; data = '0; amb = '0; lp = 1'b0;
    det = 6'd63; lvl = 8'd255; hfp = '0; hlp = '0; tfp = '0; tlp = '0; skip = '0;
    apply_reset();

    // R2: every skip setting; accepted values are 1, s+2, 2s+3, 3s+4.
    for (int s = 0; s < 16; s++) begin
      skip = 4'(s);
      apply_reset();
      for (int i = 0; i < 4 * (s + 1); i++) step(i + 1);
      chk("R2 skip average", int'(avg), (6 * s + 10) / 4);
    end
    skip = '0;
    apply_reset();

    // R3: floor of the mean.
    amb = 16'd1000;
    step(1001); step(1002); step(1003); step(1007);
    chk("R3 floor mean", int'(avg), 1003);

    // R4: rate comparator at threshold 32 and one past, both signs.
    det = 6'd2;
    step(1000); step(1000); step(1032); step(1000); chk("R4 at +thr", int'(prox), 0);
    step(1000); step(1000); step(1033); step(1000); chk("R4 past +thr", int'(prox), 1);
    step(1000); step(1000); step(968);  step(1000); chk("R4 at -thr", int'(prox), 0);
    step(1000); step(1000); step(967);  step(1000); chk("R4 past -thr", int'(prox), 1);

    // R5: level comparator at threshold 48 and one past, both signs.
    det = 6'd63; lvl = 8'd3;
    repeat (4) step(1048); chk("R5 at +lvl", int'(prox), 0);
    repeat (4) step(1049); chk("R5 past +lvl", int'(prox), 1);
    repeat (4) step(952);  chk("R5 at -lvl", int'(prox), 0);
    repeat (4) step(951);  chk("R5 past -lvl", int'(prox), 1);

    // R7 / R8: every hold-off code in each mode; the other mode's field is maxed.
    lvl = 8'd1;
    lp = 1'b0; hlp = 4'd15;
    for (int h = 0; h < 16; h++) begin
      hfp = 4'(h);
      run_hold(h * 16, "R7 full-power hold-off", 1'b0);
    end
    lp = 1'b1; hfp = 4'd15;
    for (int h = 0; h < 16; h++) begin
      hlp = 4'(h);
      run_hold(h * 4, "R8 low-power hold-off", 1'b0);
    end

    // R9: restart during hold-off.
    lp = 1'b0; hfp = 4'd2;
    run_hold(32, "R9 restarted hold-off", 1'b1);

    // R10: timeouts per mode, then disabled.
    hfp = '0; hlp = '0;
    tfp = 10'd5; tlp = 6'd63;
    settle();
    count_pulse(5, "R10 full-power timeout");
    repeat (5) @(negedge clk);
    chk("R11 cal_en idle", int'(cal_en), 1);
    chk("R11 recal idle", int'(recal), 0);
    count_pulse(5, "R10 second timeout");
    lp = 1'b1; tlp = 6'd3; tfp = 10'd1000;
    settle();
    count_pulse(3, "R10 low-power timeout");
    lp = 1'b0; tfp = '0;
    settle();
    begin
      int pulses = 0;
      for (int i = 0; i < 40; i++) begin step(1100); pulses += int'(recal); end
      chk("R10 zero timeout disabled", pulses, 0);
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule